// File: doc/BRIEF.md
# Run-time programmable clock divider with 50% duty

This block derives a slower clock from its input clock by an integer ratio between 1 and 100, with the output high for exactly half of every output period whether the ratio is even or odd. Software sets the ratio by writing a control register on the input clock. Odd ratios need a transition halfway through an input cycle, so the block keeps one counter on the rising input edge and one on the falling input edge. Each counter advances by taking the other counter's latest value plus one, so together they count half input cycles.

A written ratio first goes into a holding register. It is copied into the working ratio only at the rising input edge that ends an output period. A change of ratio therefore never cuts an output pulse short and never moves the output phase. A ratio of 1 sends the input clock straight to the output. Register values outside the legal range are clamped to the nearest legal ratio. The working ratio and a change-pending flag can be read back on output ports.

Top module: `clkdiv_prog`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0, `ratio_now` reads 1 and `ratio_pending` reads 0. This holds as soon as reset is asserted, without waiting for a clock edge.
- R2: A value written on `wr_data` is clamped to the range 1 to 100. A value of 0 becomes 1 and any value above 100 becomes 100. Once the new ratio takes effect, `ratio_now` reports the clamped value.
- R3: For an even ratio N, the `clk_out` period is N input cycles and the output is high for N/2 input cycles. The high time starts on a rising input edge.
- R4: For an odd ratio N of 3 or more, the `clk_out` period is N input cycles and the output is high for exactly N/2 input cycles, which is N half-cycles. The output rises on a rising input edge and falls on a falling input edge.
- R5: With a ratio of 1, `clk_out` follows `clk_in`: the period is one input cycle and the high time is half an input cycle.
- R6: The working ratio changes only at the rising input edge that ends an output period. While the ratio changes, no `clk_out` pulse, high or low, is shorter than half the shorter of the old and new output periods.
- R7: A written ratio takes effect at most N_old input cycles after the edge that samples the write, where N_old is the ratio in effect when the write is sampled.
- R8: `ratio_pending` reads 1 from the cycle after a write until the cycle after that write's value is loaded into the working ratio. Otherwise it reads 0.
- R9: Suppose a write is sampled on the same edge that ends an output period. Then that edge loads the value the holding register had before the write, `ratio_pending` stays 1, and the new value takes effect at the following period end.
- R10: If several writes arrive before a period end, only the last one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; also the clock of the register write port |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge of `clk_in` |
| wr_data | input | 8 | Requested division ratio, unsigned |
| clk_out | output | 1 | Divided clock with 50% duty |
| ratio_now | output | 7 | Ratio currently in effect |
| ratio_pending | output | 1 | 1 while a written ratio is waiting for a period end |

## Verification
A register write and the load at the end of an output period can fall on the same rising edge of `clk_in`. The bench waits for a rising edge of `clk_out`, which marks a period boundary while dividing by 4. It counts four falling input edges and raises the write strobe for exactly the edge that closes that period. It then checks three things at the ports. Right after that edge the old ratio must still read back with the pending flag still set. The pending flag must clear only four cycles later. The next measured output period must match the newly written ratio.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Clamp a raw register value into the legal ratio range 1..max_ratio.
  function automatic int clamp_ratio(input int raw, input int max_ratio);
    if (raw < 1) return 1;
    if (raw > max_ratio) return max_ratio;
    return raw;
  endfunction

  // Level driven from the rising-edge flop at half-count h (always even)
  // for ratio n. Even ratios: high over the first n half-cycles.
  // Odd ratios: high until the last rising edge before mid-period.
  function automatic bit rise_phase_high(input int h, input int n);
    if (n <= 1) return 1'b0;
    if ((n % 2) == 0) return h < n;
    return h < (n - 1);
  endfunction

  // Level driven from the falling-edge flop at half-count h (always odd).
  // Used only for odd ratios of 3 or more, to stretch the high time by
  // one half-cycle.
  function automatic bit fall_phase_high(input int h, input int n);
    if (n < 3) return 1'b0;
    if ((n % 2) == 0) return 1'b0;
    return h < n;
  endfunction

  // A period spans 2*n half-cycles; reaching that count closes it.
  function automatic bit half_wrap(input int h_next, input int n);
    return h_next >= 2 * n;
  endfunction

endpackage

// File: rtl/clkdiv_ratio_reg.sv
`timescale 1ns/1ps
module clkdiv_ratio_reg #(
  parameter int MAX_DIV = 100,
  parameter int DATA_W  = 8,
  parameter int DEF_DIV = 1,
  localparam int RATIO_W = $clog2(MAX_DIV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               period_end,
  output logic [RATIO_W-1:0] shadow_n,
  output logic [RATIO_W-1:0] active_n,
  output logic               pending
);
  import clkdiv_pkg::*;

  logic [RATIO_W-1:0] wr_clamped;
  always_comb wr_clamped = RATIO_W'(clamp_ratio(int'(wr_data), MAX_DIV));

  // The holding register takes every write. The working ratio copies it
  // only at a period end. A write on that same edge is not seen by the
  // load, so it stays pending for one more period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_n <= RATIO_W'(DEF_DIV);
      active_n <= RATIO_W'(DEF_DIV);
      pending  <= 1'b0;
    end else begin
      if (period_end) active_n <= shadow_n;
      if (wr_en) shadow_n <= wr_clamped;
      if (wr_en) pending <= 1'b1;
      else if (period_end) pending <= 1'b0;
    end
  end

  // R2
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_n >= RATIO_W'(1)) && (int'(active_n) <= MAX_DIV));
  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(active_n));
  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pending);
  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(period_end));

endmodule

// File: rtl/clkdiv_phase_cnt.sv
`timescale 1ns/1ps
module clkdiv_phase_cnt #(
  parameter int MAX_DIV = 100,
  localparam int RATIO_W = $clog2(MAX_DIV + 1),
  localparam int HALF_W  = $clog2(2 * MAX_DIV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] active_n,
  input  logic [RATIO_W-1:0] shadow_n,
  output logic               period_end,
  output logic               rise_q,
  output logic               fall_q,
  output logic               bypass_q
);
  import clkdiv_pkg::*;

  logic [HALF_W-1:0] h_rise;
  logic [HALF_W-1:0] h_fall;
  logic [HALF_W:0]   rise_next;
  logic [HALF_W:0]   fall_next;
  logic              fall_wrap;

  // Each counter takes the other's latest value plus one.
  always_comb begin
    rise_next  = {1'b0, h_fall} + 1'b1;
    fall_next  = {1'b0, h_rise} + 1'b1;
    period_end = half_wrap(int'(rise_next), int'(active_n));
    fall_wrap  = half_wrap(int'(fall_next), int'(active_n));
  end

  // Reset parks the falling counter at its top value, so the first rising
  // edge closes a period and starts a fresh one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rise   <= '0;
      rise_q   <= 1'b0;
      bypass_q <= 1'b0;
    end else if (period_end) begin
      h_rise   <= '0;
      rise_q   <= rise_phase_high(0, int'(shadow_n));
      bypass_q <= (shadow_n == RATIO_W'(1));
    end else begin
      h_rise   <= HALF_W'(rise_next);
      rise_q   <= rise_phase_high(int'(rise_next), int'(active_n));
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_fall <= '1;
      fall_q <= 1'b0;
    end else if (fall_wrap) begin
      h_fall <= '0;
      fall_q <= 1'b0;
    end else begin
      h_fall <= HALF_W'(fall_next);
      fall_q <= fall_phase_high(int'(fall_next), int'(active_n));
    end
  end

  // R3
  even_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_n[0] |-> !fall_q);
  // R4
  half_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, h_rise} < ((HALF_W+1)'(active_n) << 1)));
  // R5
  unit_ratio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_n == RATIO_W'(1)) |-> (!rise_q && !fall_q));

endmodule

// File: rtl/clkdiv_out_mux.sv
`timescale 1ns/1ps
module clkdiv_out_mux (
  input  logic clk,
  input  logic bypass_q,
  input  logic rise_q,
  input  logic fall_q,
  output logic clk_out
);
  // The rising-edge and falling-edge levels overlap, so their OR changes
  // once per half period. The bypass path is enabled only at a period end,
  // when both levels are low.
  always_comb clk_out = (bypass_q & clk) | rise_q | fall_q;
endmodule

// File: rtl/clkdiv_prog.sv
`timescale 1ns/1ps
module clkdiv_prog #(
  parameter int MAX_DIV = 100,
  parameter int DATA_W  = 8,
  parameter int DEF_DIV = 1,
  localparam int RATIO_W = $clog2(MAX_DIV + 1)
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               clk_out,
  output logic [RATIO_W-1:0] ratio_now,
  output logic               ratio_pending
);
  logic [RATIO_W-1:0] shadow_n;
  logic               period_end;
  logic               rise_q;
  logic               fall_q;
  logic               bypass_q;

  clkdiv_ratio_reg #(.MAX_DIV(MAX_DIV), .DATA_W(DATA_W), .DEF_DIV(DEF_DIV)) u_ratio (
    .clk(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .period_end(period_end), .shadow_n(shadow_n), .active_n(ratio_now),
    .pending(ratio_pending)
  );

  clkdiv_phase_cnt #(.MAX_DIV(MAX_DIV)) u_phase (
    .clk(clk_in), .rst_n(rst_n), .active_n(ratio_now), .shadow_n(shadow_n),
    .period_end(period_end), .rise_q(rise_q), .fall_q(fall_q),
    .bypass_q(bypass_q)
  );

  clkdiv_out_mux u_mux (
    .clk(clk_in), .bypass_q(bypass_q), .rise_q(rise_q), .fall_q(fall_q),
    .clk_out(clk_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk_in)
    !rst_n |-> !clk_out);

endmodule

// File: tb/test_clkdiv_prog.sv
`timescale 1ns/1ps
module test_clkdiv_prog;
  logic       clk_in = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       clk_out;
  logic [6:0] ratio_now;
  logic       ratio_pending;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  int  cur = 1;

  longint last_edge = 0;
  longint min_w = 0;
  bit     mon_on = 1'b0;

  localparam int NVEC = 11;
  localparam int VIN [NVEC] = '{4, 3, 1, 0, 7, 2, 150, 9, 100, 5, 4};
  localparam int VEXP[NVEC] = '{4, 3, 1, 1, 7, 2, 100, 9, 100, 5, 4};

  always #5 clk_in = ~clk_in;

  clkdiv_prog i_clkdiv_prog (
    .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clk_out(clk_out), .ratio_now(ratio_now), .ratio_pending(ratio_pending)
  );

  always @(posedge clk_out or negedge clk_out) begin
    if (mon_on && ($time - last_edge) < min_w) min_w = $time - last_edge;
    last_edge = $time;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic write_ratio(input int raw);
    @(negedge clk_in);
    wr_en = 1'b1;
    wr_data = 8'(raw);
    @(negedge clk_in);
    wr_en = 1'b0;
  endtask

  task automatic wait_load(output int c);
    c = 0;
    while (ratio_pending && c < 400) begin
      @(negedge clk_in);
      c++;
    end
  endtask

  task automatic measure(input int n, input string req);
    longint t0, t1, t2;
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    chk((t1 - t0) == n * 5, req, "high time ns", t1 - t0, n * 5);
    chk((t2 - t0) == n * 10, req, "period ns", t2 - t0, n * 10);
  endtask

  task automatic run_vec(input int raw, input int expn);
    int c;
    string req;
    req = (expn == 1) ? "R5" : ((expn % 2) == 1 ? "R4" : "R3");
    min_w = 64'd1000000;
    mon_on = 1'b1;
    write_ratio(raw);
    chk(ratio_pending == 1'b1, "R8", "pending after write", ratio_pending, 1);
    wait_load(c);
    chk(c >= 1 && c <= cur, "R7", "cycles to load", c, cur);
    chk(int'(ratio_now) == expn, "R2", "ratio_now", ratio_now, expn);
    measure(expn, req);
    mon_on = 1'b0;
    chk(min_w >= 5 * ((cur < expn) ? cur : expn), "R6", "shortest pulse ns",
        min_w, 5 * ((cur < expn) ? cur : expn));
    cur = expn;
  endtask

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    finish_run();
  end

  initial begin
    int c;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    // R1 reset state
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_in); #2;
      chk(clk_out == 1'b0, "R1", "clk_out in reset", clk_out, 0);
    end
    chk(ratio_now == 7'd1, "R1", "ratio_now in reset", ratio_now, 1);
    chk(ratio_pending == 1'b0, "R1", "pending in reset", ratio_pending, 0);
    @(negedge clk_in);
    rst_n = 1'b1;
    measure(1, "R5");

    for (int i = 0; i < NVEC; i++) run_vec(VIN[i], VEXP[i]);

    // R9 write lands on the edge closing a period while dividing by 4
    @(posedge clk_out);
    repeat (4) @(negedge clk_in);
    wr_en = 1'b1;
    wr_data = 8'd6;
    @(negedge clk_in);
    wr_en = 1'b0;
    chk(ratio_now == 7'd4, "R9", "ratio kept at collision", ratio_now, 4);
    chk(ratio_pending == 1'b1, "R9", "pending kept at collision", ratio_pending, 1);
    wait_load(c);
    chk(c == 4, "R9", "cycles to deferred load", c, 4);
    chk(ratio_now == 7'd6, "R9", "ratio after deferred load", ratio_now, 6);
    measure(6, "R9");
    cur = 6;

    // R10 two writes before a period end: the last one wins
    write_ratio(8);
    write_ratio(3);
    wait_load(c);
    chk(ratio_now == 7'd3, "R10", "last write wins", ratio_now, 3);
    measure(3, "R10");

    // R1 asynchronous reset in mid-run
    write_ratio(5);
    wait_load(c);
    @(posedge clk_out); #7;
    rst_n = 1'b0;
    #1;
    chk(clk_out == 1'b0, "R1", "clk_out after async reset", clk_out, 0);
    chk(ratio_now == 7'd1, "R1", "ratio after async reset", ratio_now, 1);
    chk(ratio_pending == 1'b0, "R1", "pending after async reset", ratio_pending, 0);
    repeat (2) @(negedge clk_in);
    finish_run();
  end
endmodule